// File: doc/BRIEF.md
# Regulator Protection and Power-Good Supervisor

This block is the digital supervisor that sits beside a step-down regulator's analog core. It receives a digitized die temperature in whole degrees, a digitized output voltage in millivolts, the nominal target voltage and a flag from the soft-start ramp. From these it decides whether the converter may switch and raises thermal and power-good flags for the rest of the chip. The converter runs only while both the enable pin and the enable bit from the serial host are high.

Three temperature comparators with hysteresis drive a shutdown flag, a warning flag and a pre-warning flag whose trip point is picked by a 2-bit code. A shutdown either clears itself once the die has cooled, with a fresh soft-start, or latches until the converter is disabled. An undervoltage detector is armed only in normal regulation, after soft-start has finished. When it trips, the converter stops for a programmable number of clock ticks and then starts again from soft-start. Power-good follows the output with separate rising and falling thresholds, and is gated by its own enable bit.

Top module: `buckSupervisor`

## Requirements
- R1: When `tempC` is 150 or more, `thermShutdown` is high and `runConv` is low two clock edges later. A value of 149 leaves both unchanged.
- R2: With `rearmAuto`=1, a shutdown holds while `tempC` is 121 or more. Two edges after `tempC` falls to 120 or less, `thermShutdown` drops and `runConv` rises in soft-start, with undervoltage detection still disarmed.
- R3: With `rearmAuto`=0, a shutdown stays set after the die cools. Only a low level on `enPin` or `hostEnable` clears it. After enable returns, the converter starts again.
- R4: One edge after `tempC` reaches 135, `thermWarn` sets. It stays set while `tempC` is 121 or more and clears one edge after `tempC` is 120 or less.
- R5: `thermPreWarn` sets at a level of 83 + 11×`preWarnSel` degrees (00→83, 01→94, 10→105, 11→116). It clears at 6 degrees below that level. Both changes take one edge.
- R6: While the converter is in soft-start (`softStartDone` low), an output below 400 mV never starts a hiccup.
- R7: Once in regulation, an output below 400 mV drives `hiccupReq` high and `runConv` low for exactly `HICCUP_TICKS` cycles. The converter then resumes in soft-start.
- R8: One edge after `voutMv`×100 ≥ `targetMv`×94, `powerGood` rises. It falls when `voutMv`×100 < `targetMv`×90 and holds its value in between.
- R9: With `pgEnable`=0, `powerGood` is low one edge later, whatever the output voltage.
- R10: During and after reset, all outputs are low. `runConv` is high only while `enPin` and `hostEnable` are both high. Dropping either one ends a hiccup or a shutdown within two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempC | input | TEMP_W | Die temperature, whole degrees Celsius |
| voutMv | input | MV_W | Measured output voltage, mV |
| targetMv | input | MV_W | Nominal output voltage, mV |
| softStartDone | input | 1 | Soft-start ramp has finished |
| enPin | input | 1 | Enable pin level |
| hostEnable | input | 1 | Enable bit written by the serial host |
| rearmAuto | input | 1 | 1: shutdown clears on cooling; 0: shutdown latches |
| preWarnSel | input | 2 | Pre-warning threshold code |
| pgEnable | input | 1 | Power-good enable |
| thermShutdown | output | 1 | Converter held off for temperature |
| thermWarn | output | 1 | Temperature warning flag |
| thermPreWarn | output | 1 | Temperature pre-warning flag |
| powerGood | output | 1 | Output within regulation |
| hiccupReq | output | 1 | Undervoltage hiccup in progress |
| runConv | output | 1 | Converter allowed to switch |

## Verification
The bench builds the block with `HICCUP_TICKS`=6, an 8-bit temperature and a 12-bit voltage, and keeps every other parameter at its default. With this short hiccup window the bench can count the whole off period cycle by cycle and compare it to the parameter. It also leaves room to watch the restarted soft-start that follows. Because the thresholds keep their defaults, each of the four pre-warning codes can be swept to its set and clear boundaries, next to the 135/120 and 150/120 edges.

// File: rtl/buckSupPkg.sv
package buckSupPkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SOFT,
    ST_RUN,
    ST_HICCUP,
    ST_THERM
  } supState_t;

  // control -> datapath
  typedef struct packed {
    logic uvArm;
    logic hiccupLoad;
    logic hiccupRun;
  } supStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic tsdHot;
    logic uvTrip;
    logic hiccupDone;
  } supStatus_t;

endpackage

// File: rtl/hystFlag.sv
module hystFlag #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] value,
  input  logic [W-1:0] setLvl,
  input  logic [W-1:0] clrLvl,
  output logic         flag
);

  always_ff @(posedge clk) begin
    if (!rstN)                flag <= 1'b0;
    else if (value >= setLvl) flag <= 1'b1;
    else if (value <= clrLvl) flag <= 1'b0;
  end

  // shared by R1, R4 and R5: a flag only rises on a sample at or above its set level
  assert_rise_needs_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> ($past(value) >= $past(setLvl)));

  // shared by R2, R4 and R5: a flag only falls on a sample at or below its clear level
  assert_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> ($past(value) <= $past(clrLvl)));

endmodule

// File: rtl/buckSupDatapath.sv
module buckSupDatapath
  import buckSupPkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int MV_W         = 12,
  parameter int TSD_SET      = 150,
  parameter int TSD_HYST     = 30,
  parameter int WARN_SET     = 135,
  parameter int WARN_HYST    = 15,
  parameter int PRE_BASE     = 83,
  parameter int PRE_STEP     = 11,
  parameter int PRE_HYST     = 6,
  parameter int UV_MV        = 400,
  parameter int PG_RISE_PCT  = 94,
  parameter int PG_FALL_PCT  = 90,
  parameter int HICCUP_TICKS = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempC,
  input  logic [MV_W-1:0]   voutMv,
  input  logic [MV_W-1:0]   targetMv,
  input  logic [1:0]        preWarnSel,
  input  logic              pgEnable,
  input  supStrobes_t       strobe,
  output supStatus_t        status,
  output logic              warnFlag,
  output logic              preFlag,
  output logic              pgFlag
);

  localparam int LVL_CNT = 3;           // 0 shutdown, 1 warning, 2 pre-warning
  localparam int PROD_W  = MV_W + 7;    // room for x100
  localparam int CNT_W   = (HICCUP_TICKS > 2) ? $clog2(HICCUP_TICKS) : 1;

  // ---------------- temperature comparators ----------------
  logic [TEMP_W-1:0] setLvl [LVL_CNT];
  logic [TEMP_W-1:0] clrLvl [LVL_CNT];
  logic [LVL_CNT-1:0] hot;
  logic [TEMP_W-1:0] preSet;

  always_comb begin
    preSet    = TEMP_W'(PRE_BASE) + TEMP_W'(PRE_STEP) * TEMP_W'(preWarnSel);
    setLvl[0] = TEMP_W'(TSD_SET);
    clrLvl[0] = TEMP_W'(TSD_SET - TSD_HYST);
    setLvl[1] = TEMP_W'(WARN_SET);
    clrLvl[1] = TEMP_W'(WARN_SET - WARN_HYST);
    setLvl[2] = preSet;
    clrLvl[2] = preSet - TEMP_W'(PRE_HYST);
  end

  for (genvar i = 0; i < LVL_CNT; i++) begin : gLvl
    hystFlag #(.W(TEMP_W)) uFlag (
      .clk    (clk),
      .rstN   (rstN),
      .value  (tempC),
      .setLvl (setLvl[i]),
      .clrLvl (clrLvl[i]),
      .flag   (hot[i])
    );
  end

  // ---------------- undervoltage ----------------
  logic uvTripQ;
  always_ff @(posedge clk) begin
    if (!rstN) uvTripQ <= 1'b0;
    else       uvTripQ <= strobe.uvArm && (voutMv < MV_W'(UV_MV));
  end

  // ---------------- hiccup timer ----------------
  logic [CNT_W-1:0] hiccupCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                 hiccupCnt <= '0;
    else if (strobe.hiccupLoad)                hiccupCnt <= CNT_W'(HICCUP_TICKS - 1);
    else if (strobe.hiccupRun && hiccupCnt != '0) hiccupCnt <= hiccupCnt - 1'b1;
  end

  // ---------------- power good ----------------
  logic [PROD_W-1:0] voutScaled, riseLvl, fallLvl;
  logic pgQ;
  always_comb begin
    voutScaled = PROD_W'(voutMv)   * PROD_W'(100);
    riseLvl    = PROD_W'(targetMv) * PROD_W'(PG_RISE_PCT);
    fallLvl    = PROD_W'(targetMv) * PROD_W'(PG_FALL_PCT);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !pgEnable)        pgQ <= 1'b0;
    else if (voutScaled >= riseLvl) pgQ <= 1'b1;
    else if (voutScaled <  fallLvl) pgQ <= 1'b0;
  end

  assign status.tsdHot     = hot[0];
  assign status.uvTrip     = uvTripQ;
  assign status.hiccupDone = (hiccupCnt == '0);
  assign warnFlag          = hot[1];
  assign preFlag           = hot[2];
  assign pgFlag            = pgQ;

  assert_pg_rise_at_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgQ) |-> $past(pgEnable) && ($past(voutScaled) >= $past(riseLvl)));

  assert_pg_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pgEnable |=> !pgQ);

  assert_uv_only_when_armed_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvTripQ) |-> $past(strobe.uvArm));

endmodule

// File: rtl/buckSupControl.sv
module buckSupControl
  import buckSupPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enPin,
  input  logic        hostEnable,
  input  logic        rearmAuto,
  input  logic        softStartDone,
  input  supStatus_t  status,
  output supStrobes_t strobe,
  output logic        thermShutdown,
  output logic        hiccupReq,
  output logic        runConv
);

  supState_t state, nextState;
  logic enabled;

  assign enabled = enPin && hostEnable;

  always_comb begin
    nextState = state;
    if (!enabled) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:    nextState = status.tsdHot ? ST_THERM : ST_SOFT;
        ST_SOFT:   nextState = status.tsdHot ? ST_THERM :
                               softStartDone ? ST_RUN : ST_SOFT;
        ST_RUN:    nextState = status.tsdHot ? ST_THERM :
                               status.uvTrip ? ST_HICCUP : ST_RUN;
        ST_HICCUP: nextState = status.tsdHot ? ST_THERM :
                               status.hiccupDone ? ST_SOFT : ST_HICCUP;
        ST_THERM:  nextState = (rearmAuto && !status.tsdHot) ? ST_SOFT : ST_THERM;
        default:   nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strobe.uvArm      = (state == ST_RUN);
    strobe.hiccupLoad = (nextState == ST_HICCUP) && (state != ST_HICCUP);
    strobe.hiccupRun  = (state == ST_HICCUP);
  end

  assign runConv       = (state == ST_SOFT) || (state == ST_RUN);
  assign thermShutdown = (state == ST_THERM);
  assign hiccupReq     = (state == ST_HICCUP);

  assert_hot_halts_run_R1: assert property (@(posedge clk) disable iff (!rstN)
    status.tsdHot |=> !runConv);

  assert_cool_restarts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_THERM) && rearmAuto && !status.tsdHot && enabled |=> runConv);

  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    thermShutdown && !rearmAuto && enabled |=> thermShutdown);

  assert_soft_start_no_hiccup_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SOFT) |=> !hiccupReq);

  assert_uv_enters_hiccup_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) && status.uvTrip && !status.tsdHot && enabled |=> hiccupReq);

  assert_run_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    runConv |-> $past(enabled));

endmodule

// File: rtl/buckSupervisor.sv
module buckSupervisor
  import buckSupPkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int MV_W         = 12,
  parameter int TSD_SET      = 150,
  parameter int TSD_HYST     = 30,
  parameter int WARN_SET     = 135,
  parameter int WARN_HYST    = 15,
  parameter int PRE_BASE     = 83,
  parameter int PRE_STEP     = 11,
  parameter int PRE_HYST     = 6,
  parameter int UV_MV        = 400,
  parameter int PG_RISE_PCT  = 94,
  parameter int PG_FALL_PCT  = 90,
  parameter int HICCUP_TICKS = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempC,
  input  logic [MV_W-1:0]   voutMv,
  input  logic [MV_W-1:0]   targetMv,
  input  logic              softStartDone,
  input  logic              enPin,
  input  logic              hostEnable,
  input  logic              rearmAuto,
  input  logic [1:0]        preWarnSel,
  input  logic              pgEnable,
  output logic              thermShutdown,
  output logic              thermWarn,
  output logic              thermPreWarn,
  output logic              powerGood,
  output logic              hiccupReq,
  output logic              runConv
);

  supStrobes_t strobe;
  supStatus_t  status;

  buckSupDatapath #(
    .TEMP_W(TEMP_W), .MV_W(MV_W),
    .TSD_SET(TSD_SET), .TSD_HYST(TSD_HYST),
    .WARN_SET(WARN_SET), .WARN_HYST(WARN_HYST),
    .PRE_BASE(PRE_BASE), .PRE_STEP(PRE_STEP), .PRE_HYST(PRE_HYST),
    .UV_MV(UV_MV), .PG_RISE_PCT(PG_RISE_PCT), .PG_FALL_PCT(PG_FALL_PCT),
    .HICCUP_TICKS(HICCUP_TICKS)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .tempC      (tempC),
    .voutMv     (voutMv),
    .targetMv   (targetMv),
    .preWarnSel (preWarnSel),
    .pgEnable   (pgEnable),
    .strobe     (strobe),
    .status     (status),
    .warnFlag   (thermWarn),
    .preFlag    (thermPreWarn),
    .pgFlag     (powerGood)
  );

  buckSupControl uControl (
    .clk           (clk),
    .rstN          (rstN),
    .enPin         (enPin),
    .hostEnable    (hostEnable),
    .rearmAuto     (rearmAuto),
    .softStartDone (softStartDone),
    .status        (status),
    .strobe        (strobe),
    .thermShutdown (thermShutdown),
    .hiccupReq     (hiccupReq),
    .runConv       (runConv)
  );

endmodule

// File: tb/tb_buckSupervisor.sv
module tb_buckSupervisor;

  localparam int TEMP_W = 8;
  localparam int MV_W   = 12;
  localparam int HT     = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TEMP_W-1:0] tempC = 8'd25;
  logic [MV_W-1:0]   voutMv = '0;
  logic [MV_W-1:0]   targetMv = 12'd1100;
  logic softStartDone = 1'b0;
  logic enPin = 1'b0;
  logic hostEnable = 1'b0;
  logic rearmAuto = 1'b1;
  logic [1:0] preWarnSel = 2'd0;
  logic pgEnable = 1'b1;
  logic thermShutdown, thermWarn, thermPreWarn, powerGood, hiccupReq, runConv;

  always #10 clk = ~clk;   // 50 MHz

  buckSupervisor #(.TEMP_W(TEMP_W), .MV_W(MV_W), .HICCUP_TICKS(HT)) dut (
    .clk(clk), .rstN(rstN), .tempC(tempC), .voutMv(voutMv), .targetMv(targetMv),
    .softStartDone(softStartDone), .enPin(enPin), .hostEnable(hostEnable),
    .rearmAuto(rearmAuto), .preWarnSel(preWarnSel), .pgEnable(pgEnable),
    .thermShutdown(thermShutdown), .thermWarn(thermWarn), .thermPreWarn(thermPreWarn),
    .powerGood(powerGood), .hiccupReq(hiccupReq), .runConv(runConv)
  );

  typedef struct {
    string tag;
    int    sel;
    int    expVal;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic int readOut(int sel);
    case (sel)
      0: return int'(thermShutdown);
      1: return int'(thermWarn);
      2: return int'(thermPreWarn);
      3: return int'(powerGood);
      4: return int'(hiccupReq);
      default: return int'(runConv);
    endcase
  endfunction

  function automatic string outName(int sel);
    case (sel)
      0: return "thermShutdown";
      1: return "thermWarn";
      2: return "thermPreWarn";
      3: return "powerGood";
      4: return "hiccupReq";
      default: return "runConv";
    endcase
  endfunction

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        int act;
        it  = expQ.pop_front();
        act = readOut(it.sel);
        checks++;
        if (act != it.expVal) begin
          errors++;
          $display("FAIL %s: %s actual=%0d expected=%0d", it.tag, outName(it.sel), act, it.expVal);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(string tag, int sel, int val);
    expItem_t it;
    it.tag = tag; it.sel = sel; it.expVal = val;
    expQ.push_back(it);
  endtask

  task automatic flush();
    -> sampleEv;
    #1;
  endtask

  task automatic checkVal(string tag, int act, int expVal);
    checks++;
    if (act != expVal) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expVal);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog R10: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int waitN;
    int width;
    // R10 reset state
    tick(3);
    for (int s = 0; s < 6; s++) expectOut("R10 reset", s, 0);
    flush();
    rstN = 1'b1;
    tick(2);
    expectOut("R10 disabled no run", 5, 0);
    flush();

    // enable: soft-start with UV ignored
    enPin = 1'b1; hostEnable = 1'b1;
    tick(2);
    expectOut("R10 enabled runs", 5, 1);
    flush();
    tick(5);
    expectOut("R6 low vout in soft-start", 4, 0);
    expectOut("R6 still running", 5, 1);
    flush();

    softStartDone = 1'b1; voutMv = 12'd1100;
    tick(3);
    expectOut("R8 pg rises at target", 3, 1);
    expectOut("R7 no hiccup at target", 4, 0);
    flush();

    // R8 power-good thresholds, target 1000
    targetMv = 12'd1000;
    voutMv = 12'd899; tick(1); expectOut("R8 below fall", 3, 0); flush();
    voutMv = 12'd939; tick(1); expectOut("R8 hold low under rise", 3, 0); flush();
    voutMv = 12'd940; tick(1); expectOut("R8 rise at 94pct", 3, 1); flush();
    voutMv = 12'd900; tick(1); expectOut("R8 hold at 90pct", 3, 1); flush();
    voutMv = 12'd899; tick(1); expectOut("R8 fall below 90pct", 3, 0); flush();
    voutMv = 12'd1000; tick(1); expectOut("R8 back high", 3, 1); flush();
    pgEnable = 1'b0; tick(1); expectOut("R9 gated low", 3, 0); flush();
    pgEnable = 1'b1; tick(1); expectOut("R9 ungated", 3, 1); flush();

    // R5 pre-warning codes
    for (int c = 0; c < 4; c++) begin
      int thr;
      thr = 83 + 11 * c;
      preWarnSel = 2'(c);
      tempC = 8'd25; tick(1);
      tempC = 8'(thr - 1); tick(1); expectOut($sformatf("R5 code%0d below", c), 2, 0); flush();
      tempC = 8'(thr);     tick(1); expectOut($sformatf("R5 code%0d set", c), 2, 1); flush();
      tempC = 8'(thr - 5); tick(1); expectOut($sformatf("R5 code%0d hold", c), 2, 1); flush();
      tempC = 8'(thr - 6); tick(1); expectOut($sformatf("R5 code%0d clear", c), 2, 0); flush();
    end

    // R4 warning
    tempC = 8'd134; tick(1); expectOut("R4 below warn", 1, 0); flush();
    tempC = 8'd135; tick(1); expectOut("R4 warn set", 1, 1); flush();
    tempC = 8'd121; tick(1); expectOut("R4 warn hold", 1, 1); flush();
    tempC = 8'd120; tick(1); expectOut("R4 warn clear", 1, 0); flush();

    // R1/R2 auto-rearm shutdown
    tempC = 8'd149; tick(2);
    expectOut("R1 149 no shutdown", 0, 0); expectOut("R1 149 runs", 5, 1); flush();
    tempC = 8'd150; tick(2);
    expectOut("R1 shutdown set", 0, 1); expectOut("R1 run stopped", 5, 0); flush();
    softStartDone = 1'b0; voutMv = 12'd100;
    tempC = 8'd121; tick(2);
    expectOut("R2 hold at 121", 0, 1); expectOut("R2 still off", 5, 0); flush();
    tempC = 8'd120; tick(2);
    expectOut("R2 released", 0, 0); expectOut("R2 restart run", 5, 1); flush();
    tick(4);
    expectOut("R2 uv disarmed after restart", 4, 0); flush();

    // R7 hiccup
    softStartDone = 1'b1;
    waitN = 0;
    while (!hiccupReq && waitN < 20) begin tick(1); waitN++; end
    checkVal("R7 hiccup entered", int'(hiccupReq), 1);
    softStartDone = 1'b0;
    expectOut("R7 run low in hiccup", 5, 0); flush();
    width = 0;
    while (hiccupReq && width < 100) begin width++; tick(1); end
    checkVal("R7 hiccup width", width, HT);
    expectOut("R7 resumes soft-start", 5, 1); flush();
    tick(5);
    expectOut("R6 no hiccup in restarted soft-start", 4, 0); flush();

    // R10 enable drop aborts hiccup
    softStartDone = 1'b1;
    waitN = 0;
    while (!hiccupReq && waitN < 20) begin tick(1); waitN++; end
    hostEnable = 1'b0; tick(2);
    expectOut("R10 hiccup ended by disable", 4, 0); expectOut("R10 off when disabled", 5, 0); flush();
    hostEnable = 1'b1; voutMv = 12'd1000; tick(2);
    expectOut("R10 re-enabled runs", 5, 1); flush();

    // R3 latched shutdown
    rearmAuto = 1'b0;
    tempC = 8'd150; tick(2);
    expectOut("R3 shutdown set", 0, 1); flush();
    tempC = 8'd25; tick(4);
    expectOut("R3 latched when cool", 0, 1); expectOut("R3 stays off", 5, 0); flush();
    enPin = 1'b0; tick(2);
    expectOut("R3 pin clears latch", 0, 0); flush();
    enPin = 1'b1; tick(2);
    expectOut("R3 restart after pin", 5, 1); flush();
    tempC = 8'd155; tick(2);
    expectOut("R3 shutdown again", 0, 1); flush();
    tempC = 8'd25; tick(3);
    expectOut("R3 latched again", 0, 1); flush();
    hostEnable = 1'b0; tick(2);
    expectOut("R3 host clears latch", 0, 0); flush();
    hostEnable = 1'b1; tick(2);
    expectOut("R3 restart after host", 5, 1); flush();

    finishRun();
  end

endmodule